// File: doc/BRIEF.md
# I2C Target Register Read Engine

This block is the target side of an I2C bus for a small bank of 16-bit registers. It brings SCL and SDA into the system clock domain through two-flop synchronisers. It recognises START and STOP conditions and compares the first byte of each transaction with its own 7-bit address. It drives SDA through an open-drain model: `sda_oe` high pulls the line low, and `sda_oe` low releases it.

A write transaction carries one data byte, which loads the register pointer. A read transaction returns the 16-bit register that the pointer selects, upper byte first. The engine keeps re-sending that same byte pair for as long as the controller acknowledges.

The pointer keeps its value from one transaction to the next. A controller can therefore read the same register again without first rewriting the pointer. The register bank itself lies outside the block. It is reached through a combinational read port: the block raises `rf_rd_en` with `rf_rd_addr` and takes `rf_rd_data` in the same cycle.

The control FSM has eight states:
- `ST_IDLE`: waits for START.
- `ST_ADDR`: shifts in the address byte.
- `ST_ADDR_ACK`: drives the address acknowledge.
- `ST_PTR`: shifts in the pointer byte.
- `ST_PTR_ACK`: acknowledges the pointer byte.
- `ST_TX`: shifts out a data byte.
- `ST_TX_ACK`: samples the controller's acknowledge.
- `ST_WAIT_STOP`: keeps SDA released until STOP or START.

The FSM moves between them as follows:
- START from any state goes to `ST_ADDR`.
- STOP from any state goes to `ST_IDLE`.
- From `ST_ADDR`, on the SCL fall after the eighth bit: to `ST_ADDR_ACK` when the address matches, otherwise to `ST_WAIT_STOP`.
- From `ST_ADDR_ACK`, on the next SCL fall: to `ST_TX` for a read, or to `ST_PTR` for a write.
- From `ST_PTR`, after eight bits: to `ST_PTR_ACK`.
- From `ST_PTR_ACK`, on the next SCL fall: to `ST_WAIT_STOP`.
- From `ST_TX`, after eight bits: to `ST_TX_ACK`.
- From `ST_TX_ACK`: back to `ST_TX` when the controller sent ACK, or to `ST_WAIT_STOP` when it sent NACK.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset, `sda_oe` is 0 and the pointer `ptr_o` is 0.
- R2: The first byte after START carries the address bits A6 down to A0, then the R/W bit (1 = read). When the address equals `TGT_ADDR`, the target pulls SDA low during the ninth clock.
- R3: When the address does not match, the target leaves SDA released through the acknowledge slot and every later byte until the next START or STOP, and the pointer is left unchanged.
- R4: In a write, the lower `PTR_W` bits of the first data byte load the pointer, and that byte is acknowledged. Any further byte in the same transaction is not acknowledged and leaves the pointer unchanged.
- R5: A read sends register bits 15..8 first, then bits 7..0, each byte MSB first. SDA is released during each ninth-clock acknowledge slot.
- R6: If the controller acknowledges the low byte, the target sends both bytes of the same register again. No new address frame is needed, and this repeats for as long as the controller keeps acknowledging.
- R7: A NACK from the controller ends the data phase. SDA then stays released for any further clocks, and a STOP returns the engine to idle.
- R8: The pointer keeps its value across STOP. A read with no pointer write in front of it returns the register selected by the last pointer written.
- R9: A START seen in the middle of a transaction, including in the middle of the address byte, returns the engine to address matching. The next address byte is then handled as a fresh one.
- R10: `sda_oe` changes only while the synchronised SCL is low. START and STOP are never detected in the same cycle.
- R11: `rf_rd_en` is high for exactly one cycle per 16-bit word sent, with `rf_rd_addr` equal to the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| rf_rd_en | output | 1 | One-cycle strobe: fetch a register word |
| rf_rd_addr | output | PTR_W | Register index for the fetch |
| rf_rd_data | input | 16 | Register word, valid in the strobe cycle |
| ptr_o | output | PTR_W | Current register pointer |

## Verification
The bench builds the block with its defaults: `PTR_W` = 4, `TGT_ADDR` = 0x48 and two synchroniser stages. With a 4-bit pointer, the bench register model covers every index. A pointer byte of 0xF2 shows that the upper bits are discarded, because it must select register 2. SCL runs at 1/16 of the system clock, which leaves room for the three-cycle synchroniser and edge latency before each SCL rise. The addresses 0x48 and 0x49 differ only in A0, so they probe the exact match.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int DATA_W = 16;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_WAIT_STOP
    } tgt_state_e;

endpackage

// File: rtl/i2c_tgt_sync.sv
`timescale 1ns/1ps
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int NLINE = 2;   // index 0 = SCL, 1 = SDA

    logic [NLINE-1:0] raw;
    logic [NLINE-1:0] synced;
    logic [NLINE-1:0] prev_q;

    assign raw = {sda_in, scl_in};

    // One synchroniser chain per bus line; idle level is high.
    for (genvar g = 0; g < NLINE; g++) begin : g_line
        logic [STAGES-1:0] pipe_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe_q <= '1;
            end else begin
                pipe_q <= {pipe_q[STAGES-2:0], raw[g]};
            end
        end
        assign synced[g] = pipe_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '1;
        end else begin
            prev_q <= synced;
        end
    end

    assign sda_s     = synced[1];
    assign scl_rise  = synced[0] & ~prev_q[0];
    assign scl_fall  = ~synced[0] & prev_q[0];
    assign start_det = synced[0] & prev_q[0] & prev_q[1] & ~synced[1];
    assign stop_det  = synced[0] & prev_q[0] & ~prev_q[1] & synced[1];

    AST_NO_START_AND_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_det && stop_det)); // R10

endmodule

// File: rtl/i2c_tgt_ctrl.sv
`timescale 1ns/1ps
module i2c_tgt_ctrl
    import i2c_tgt_pkg::*;
#(
    parameter int         PTR_W    = 4,
    parameter logic [6:0] TGT_ADDR = 7'h48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_en,
    output logic [PTR_W-1:0]  ptr,
    output logic              sda_oe
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    tgt_state_e        state_q, state_d;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [BYTE_W-1:0] rx_sh_q;
    logic [DATA_W-1:0] tx_sh_q;
    logic              rw_q;
    logic              byte_lo_q;
    logic              ack_seen_q;
    logic              oe_q;
    logic [PTR_W-1:0]  ptr_q;

    logic rx_full;
    logic addr_hit;
    logic bus_evt;
    logic load_word;

    assign rx_full  = (bit_cnt_q == CNT_FULL);
    assign addr_hit = (rx_sh_q[BYTE_W-1:1] == TGT_ADDR);
    assign bus_evt  = start_det | stop_det;

    // Fetch a word when a read begins, or when the controller ACKs a low byte.
    assign load_word = scl_fall && !bus_evt &&
                       (((state_q == ST_ADDR_ACK) && rw_q) ||
                        ((state_q == ST_TX_ACK) && ack_seen_q && byte_lo_q));

    // Next-state decision
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_ADDR:      if (scl_fall && rx_full)
                                  state_d = addr_hit ? ST_ADDR_ACK : ST_WAIT_STOP;
                ST_ADDR_ACK:  if (scl_fall)
                                  state_d = rw_q ? ST_TX : ST_PTR;
                ST_PTR:       if (scl_fall && rx_full)
                                  state_d = ST_PTR_ACK;
                ST_PTR_ACK:   if (scl_fall)
                                  state_d = ST_WAIT_STOP;
                ST_TX:        if (scl_fall && rx_full)
                                  state_d = ST_TX_ACK;
                ST_TX_ACK:    if (scl_fall)
                                  state_d = ack_seen_q ? ST_TX : ST_WAIT_STOP;
                ST_WAIT_STOP: state_d = ST_WAIT_STOP;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q  <= '0;
            rx_sh_q    <= '0;
            tx_sh_q    <= '0;
            rw_q       <= 1'b0;
            byte_lo_q  <= 1'b0;
            ack_seen_q <= 1'b0;
            oe_q       <= 1'b0;
            ptr_q      <= '0;
        end else if (bus_evt) begin
            oe_q      <= 1'b0;
            bit_cnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_ADDR, ST_PTR: begin
                    if (scl_rise && !rx_full) begin
                        rx_sh_q   <= {rx_sh_q[BYTE_W-2:0], sda_s};
                        bit_cnt_q <= bit_cnt_q + CNT_ONE;
                    end
                    if (scl_fall && rx_full) begin
                        bit_cnt_q <= '0;
                        if (state_q == ST_ADDR) begin
                            oe_q <= addr_hit;
                            rw_q <= rx_sh_q[0];
                        end else begin
                            ptr_q <= rx_sh_q[PTR_W-1:0];
                            oe_q  <= 1'b1;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (rw_q) begin
                            tx_sh_q   <= {rd_data[DATA_W-2:0], 1'b0};
                            oe_q      <= ~rd_data[DATA_W-1];
                            bit_cnt_q <= CNT_ONE;
                            byte_lo_q <= 1'b0;
                        end else begin
                            oe_q      <= 1'b0;
                            bit_cnt_q <= '0;
                        end
                    end
                end
                ST_PTR_ACK: begin
                    if (scl_fall) begin
                        oe_q <= 1'b0;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (rx_full) begin
                            oe_q      <= 1'b0;
                            bit_cnt_q <= '0;
                        end else begin
                            oe_q      <= ~tx_sh_q[DATA_W-1];
                            tx_sh_q   <= {tx_sh_q[DATA_W-2:0], 1'b0};
                            bit_cnt_q <= bit_cnt_q + CNT_ONE;
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        ack_seen_q <= ~sda_s;
                    end
                    if (scl_fall) begin
                        if (!ack_seen_q) begin
                            oe_q <= 1'b0;
                        end else if (byte_lo_q) begin
                            tx_sh_q   <= {rd_data[DATA_W-2:0], 1'b0};
                            oe_q      <= ~rd_data[DATA_W-1];
                            bit_cnt_q <= CNT_ONE;
                            byte_lo_q <= 1'b0;
                        end else begin
                            oe_q      <= ~tx_sh_q[DATA_W-1];
                            tx_sh_q   <= {tx_sh_q[DATA_W-2:0], 1'b0};
                            bit_cnt_q <= CNT_ONE;
                            byte_lo_q <= 1'b1;
                        end
                    end
                end
                default: begin
                    oe_q <= 1'b0;
                end
            endcase
        end
    end

    assign rd_en  = load_word;
    assign ptr    = ptr_q;
    assign sda_oe = oe_q;

    AST_OE_MOVES_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_fall && !start_det && !stop_det) |=> $stable(sda_oe)); // R10
    AST_WAIT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_STOP) |-> !sda_oe); // R3
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sda_oe); // R1
    AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state_q == ST_ADDR && !sda_oe && bit_cnt_q == '0)); // R9
    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state_q == ST_IDLE && !sda_oe)); // R7
    AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_q == ST_PTR && scl_fall) |=> $stable(ptr)); // R8
    AST_FETCH_ONLY_READING: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (state_q == ST_TX && !rw_q == 1'b0)); // R11

endmodule

// File: rtl/i2c_reg_target.sv
`timescale 1ns/1ps
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter int         PTR_W       = 4,
    parameter logic [6:0] TGT_ADDR    = 7'h48,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic              rf_rd_en,
    output logic [PTR_W-1:0]  rf_rd_addr,
    input  logic [DATA_W-1:0] rf_rd_data,
    output logic [PTR_W-1:0]  ptr_o
);
    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [PTR_W-1:0] ptr;

    i2c_tgt_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_ctrl #(
        .PTR_W    (PTR_W),
        .TGT_ADDR (TGT_ADDR)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rf_rd_data),
        .rd_en     (rf_rd_en),
        .ptr       (ptr),
        .sda_oe    (sda_oe)
    );

    assign rf_rd_addr = ptr;
    assign ptr_o      = ptr;

endmodule

// File: tb/test_i2c_reg_target.sv
`timescale 1ns/1ps
module test_i2c_reg_target;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        ctrl_low = 1'b0;
    logic        sda_oe;
    logic        rf_rd_en;
    logic [3:0]  rf_rd_addr;
    logic [15:0] rf_rd_data;
    logic [3:0]  ptr_o;
    wire         sda_line = ~(ctrl_low | sda_oe);

    int n_checks = 0;
    int n_bad    = 0;
    int rd_cnt   = 0;
    int line_viol = 0;
    logic prev_oe = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [15:0] exp_reg(logic [3:0] i);
        return {i ^ 4'hA, i, ~i, i ^ 4'h5};
    endfunction

    assign rf_rd_data = exp_reg(rf_rd_addr);

    i2c_reg_target i_i2c_reg_target (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl),
        .sda_in     (sda_line),
        .sda_oe     (sda_oe),
        .rf_rd_en   (rf_rd_en),
        .rf_rd_addr (rf_rd_addr),
        .rf_rd_data (rf_rd_data),
        .ptr_o      (ptr_o)
    );

    // Fetch counter and the SDA-changes-only-while-SCL-low monitor (R10, R11)
    always @(negedge clk) begin
        if (rst_n) begin
            if (rf_rd_en) begin
                rd_cnt++;
                if (rf_rd_addr !== ptr_o) line_viol++;
            end
            if (sda_oe !== prev_oe && scl) line_viol++;
        end
        prev_oe <= sda_oe;
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        ctrl_low = 1'b0; tick(4);
        scl = 1'b1;      tick(8);
        ctrl_low = 1'b1; tick(8);
        scl = 1'b0;      tick(4);
    endtask

    task automatic bus_stop();
        ctrl_low = 1'b1; tick(4);
        scl = 1'b1;      tick(8);
        ctrl_low = 1'b0; tick(8);
    endtask

    task automatic put_bit(input logic b);
        ctrl_low = ~b; tick(4);
        scl = 1'b1;    tick(8);
        scl = 1'b0;    tick(4);
    endtask

    task automatic get_bit(output logic b);
        ctrl_low = 1'b0; tick(4);
        scl = 1'b1;      tick(4);
        b = sda_line;    tick(4);
        scl = 1'b0;      tick(4);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(s);
        acked = ~s;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic give_ack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            get_bit(s);
            d[i] = s;
        end
        put_bit(~give_ack);
    endtask

    task automatic read_word(output logic [15:0] w, input logic ack_last);
        logic [7:0] hi, lo;
        recv_byte(hi, 1'b1);
        recv_byte(lo, ack_last);
        w = {hi, lo};
    endtask

    task automatic sc_reset();
        check("R1 sda_oe after reset", sda_oe, 0);
        check("R1 pointer after reset", ptr_o, 0);
    endtask

    task automatic sc_pointer_write();
        logic a;
        bus_start();
        send_byte(8'h90, a); check("R2 write address ACK", a, 1);
        send_byte(8'h05, a); check("R4 pointer byte ACK", a, 1);
        bus_stop();
        check("R4 pointer loaded", ptr_o, 5);
    endtask

    task automatic sc_single_read();
        logic a; logic [15:0] w; int r0;
        r0 = rd_cnt;
        bus_start();
        send_byte(8'h91, a); check("R2 read address ACK", a, 1);
        read_word(w, 1'b0);
        bus_stop();
        check("R5 word high then low", w, exp_reg(4'd5));
        check("R11 one fetch per word", rd_cnt - r0, 1);
    endtask

    task automatic sc_continuous();
        logic a; logic [15:0] w; int r0;
        r0 = rd_cnt;
        bus_start();
        send_byte(8'h91, a);
        for (int k = 0; k < 3; k++) begin
            read_word(w, k != 2);
            check("R6 repeated word", w, exp_reg(4'd5));
        end
        bus_stop();
        check("R11 fetches in continuous read", rd_cnt - r0, 3);
    endtask

    task automatic sc_nack_release();
        logic a; logic [15:0] w; logic [7:0] tail;
        bus_start();
        send_byte(8'h91, a);
        read_word(w, 1'b0);
        recv_byte(tail, 1'b0);
        check("R7 SDA released after NACK", tail, 8'hFF);
        bus_stop();
        check("R7 released after STOP", sda_oe, 0);
    endtask

    task automatic sc_addr_mismatch();
        logic a;
        bus_start();
        send_byte(8'h92, a); check("R3 mismatched address not ACKed", a, 0);
        send_byte(8'h0F, a); check("R3 byte after mismatch not ACKed", a, 0);
        bus_stop();
        check("R3 pointer untouched", ptr_o, 5);
    endtask

    task automatic sc_extra_write();
        logic a;
        bus_start();
        send_byte(8'h90, a);
        send_byte(8'hF2, a); check("R4 pointer byte ACK", a, 1);
        send_byte(8'h07, a); check("R4 second data byte NACKed", a, 0);
        bus_stop();
        check("R4 upper bits dropped, extra byte ignored", ptr_o, 2);
    endtask

    task automatic sc_persist();
        logic a; logic [15:0] w;
        bus_start();
        send_byte(8'h91, a);
        read_word(w, 1'b0);
        bus_stop();
        check("R8 read uses last pointer", w, exp_reg(4'd2));
    endtask

    task automatic sc_repeated_start();
        logic a; logic [15:0] w;
        bus_start();
        send_byte(8'h90, a);
        send_byte(8'h0B, a);
        bus_start();
        send_byte(8'h91, a); check("R9 address after repeated START", a, 1);
        read_word(w, 1'b0);
        check("R9 combined write-read word", w, exp_reg(4'd11));
        bus_stop();
        bus_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b0); put_bit(1'b1);
        bus_start();
        send_byte(8'h91, a); check("R9 restart inside address byte", a, 1);
        read_word(w, 1'b0);
        check("R9 word after restart", w, exp_reg(4'd11));
        bus_stop();
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(10);
        sc_reset();
        sc_pointer_write();
        sc_single_read();
        sc_continuous();
        sc_nack_release();
        sc_addr_mismatch();
        sc_extra_write();
        sc_persist();
        sc_repeated_start();
        check("R10 SDA moved only with SCL low, R11 fetch address", line_viol, 0);
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule